// File: doc/BRIEF.md
# Regulator Fault Protection Sequencer

This block is the digital supervisor of a single-phase synchronous buck regulator. It takes the outputs of the analog comparators as inputs: supply undervoltage for the controller and driver rails, output overvoltage, output undervoltage, overcurrent and switch-node high. It also takes the enable level and a soft-start-in-progress flag from the reference ramp. From these it decides whether the gates may switch, when a crowbar must override the PWM, whether the power-good flag is raised, and when a fault has been latched.

An overvoltage event is first handled as a recoverable crowbar: the high-side gate is forced off and the low-side gate is forced on for as long as the comparator stays tripped. Each new trip is counted, and the eighth one latches a shutdown. Overvoltage is ignored entirely while soft start runs, so the regulator can start into an output that is already charged. Overcurrent latches at once. Both latches are released only by dropping enable or by a controller-rail undervoltage.

Top module: `reg_fault_seq`

## Requirements
- R1: Every comparator input and the enable input pass through a two-flop synchroniser. A level change driven between clock edges shows on the outputs after the second following rising clock edge and not after the first.
- R2: While the controller-rail undervoltage input is 1, `gate_en` and `ss_en` are 0, and the overvoltage trip count and every fault latch are cleared.
- R3: An overcurrent input of 1 sets the fault latch: `fault_latched` becomes 1 and `gate_en` becomes 0. Both hold after the overcurrent input returns to 0, until enable is taken to 0.
- R4: While the output-undervoltage input is 1, `pgood` is 0.
- R5: While the regulator is running, soft start is not active, and the overvoltage input is 1, `force_tg_low` and `force_bg_high` are both 1 and `pgood` is 0. All three return to normal once the overvoltage input clears.
- R6: The eighth rising edge of the synchronised overvoltage input outside soft start sets `fault_latched`. The count advances once per rising edge: an input held high counts once.
- R7: While `ss_active` is 1, the overvoltage input causes no crowbar and does not advance the trip count.
- R8: When the regulator is not running, the driver-rail undervoltage input is 0 and the switch-node-high input is 1, `force_bg_high` is 1.
- R9: `ov_thr_sel` equals `ofs_active` in the same cycle. A value of 1 selects the 350 mV overvoltage threshold and 0 selects the 180 mV threshold.
- R10: `gate_en` is 1 exactly when enable is 1, both rail undervoltage inputs are 0 and no fault is latched. `pgood` is 1 only when `gate_en` is 1, soft start is not active, and neither the overvoltage nor the undervoltage input is 1.
- R11: Taking enable to 0 clears the overvoltage trip count. After re-enabling, a further seven trips do not latch a fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Supervisor clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_a | input | 1 | Enable level, asynchronous |
| vcc_uv_a | input | 1 | Controller-rail undervoltage comparator |
| vccp_uv_a | input | 1 | Driver-rail undervoltage comparator |
| ov_a | input | 1 | Output overvoltage comparator |
| uv_a | input | 1 | Output undervoltage comparator (300 mV below reference) |
| oc_a | input | 1 | Overcurrent comparator |
| sw_high_a | input | 1 | Switch node sensed high |
| ss_active | input | 1 | Soft-start ramp in progress, synchronous |
| ofs_active | input | 1 | Offset function active, synchronous |
| gate_en | output | 1 | PWM gates allowed to switch |
| ss_en | output | 1 | Soft-start ramp allowed to run |
| force_tg_low | output | 1 | Override: high-side gate off |
| force_bg_high | output | 1 | Override: low-side gate on |
| pgood | output | 1 | Power-good flag |
| fault_latched | output | 1 | Overcurrent or overvoltage shutdown latched |
| ov_thr_sel | output | 1 | Overvoltage threshold select to comparator |

## Verification
The overvoltage input is tried as short pulses, as a long level that must count once, as pulses during soft start that must be neither counted nor crowbarred, and as a run of seven pulses around an enable toggle. Together these separate edge counting from level counting and show that the count is blanked and cleared. Rare overcurrent pulses, enable drops and rail undervoltage events are mixed into a random run. A reference model checks every output on every cycle, which separates the priority of each latch clear from its set. A directed step on the undervoltage input checks that the synchroniser latency is exactly two edges.

// File: rtl/rfs_pkg.sv
// Package: shared indices and limits for the regulator fault sequencer.
// Assumes one bit per asynchronous input, packed in the order given below.
package rfs_pkg;
    localparam int unsigned NUM_ASYNC   = 7;
    localparam int unsigned IDX_EN      = 0;
    localparam int unsigned IDX_VCC_UV  = 1;
    localparam int unsigned IDX_VCCP_UV = 2;
    localparam int unsigned IDX_OV      = 3;
    localparam int unsigned IDX_UV      = 4;
    localparam int unsigned IDX_OC      = 5;
    localparam int unsigned IDX_SW      = 6;
    localparam int unsigned DEF_SYNC_STAGES = 2;
    localparam int unsigned DEF_OV_LIMIT    = 8;
endpackage

// File: rtl/rfs_sync.sv
// Module: multi-stage level synchroniser for a vector of asynchronous inputs.
// Assumes each bit is an independent slow level; no bus coherency is implied.
module rfs_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_a,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    // Purpose: shift each input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(STAGES); i++) chain[i] <= '0;
        end else begin
            chain[0] <= d_a;
            for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/rfs_sticky.sv
// Module: set/clear latch for a single fault; clear dominates set.
// Assumes set and clr are synchronous to clk.
module rfs_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic q
);
    // Purpose: hold the fault until cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) q <= 1'b0;
        else if (set)      q <= 1'b1;
    end
endmodule

// File: rtl/rfs_ov_counter.sv
// Module: counts rising edges of overvoltage outside a blanking window and
// latches shutdown on the LIMIT-th counted edge.
// Assumes ov_lvl is already synchronised; blank is a synchronous level.
module rfs_ov_counter #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ov_lvl,
    input  logic blank,
    output logic shut
);
    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic          ov_prev;
    logic [CW-1:0] cnt;
    logic          rise;

    // Purpose: remember the previous overvoltage level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) ov_prev <= 1'b0;
        else        ov_prev <= ov_lvl;
    end

    assign rise = ov_lvl & ~ov_prev;

    // Purpose: advance the trip count and latch shutdown at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt  <= '0;
            shut <= 1'b0;
        end else if (rise && !blank && !shut) begin
            if (cnt == LAST) shut <= 1'b1;
            else             cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/reg_fault_seq.sv
// Module: fault protection sequencer for a single-phase buck regulator.
// Synchronises comparator levels, latches overcurrent and repeated
// overvoltage, drives gate overrides and the power-good flag.
// Assumes ss_active and ofs_active are already synchronous to clk.
module reg_fault_seq #(
    parameter int unsigned SYNC_STAGES = rfs_pkg::DEF_SYNC_STAGES,
    parameter int unsigned OV_LIMIT    = rfs_pkg::DEF_OV_LIMIT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_a,
    input  logic vcc_uv_a,
    input  logic vccp_uv_a,
    input  logic ov_a,
    input  logic uv_a,
    input  logic oc_a,
    input  logic sw_high_a,
    input  logic ss_active,
    input  logic ofs_active,
    output logic gate_en,
    output logic ss_en,
    output logic force_tg_low,
    output logic force_bg_high,
    output logic pgood,
    output logic fault_latched,
    output logic ov_thr_sel
);
    import rfs_pkg::*;

    logic [NUM_ASYNC-1:0] raw_a;
    logic [NUM_ASYNC-1:0] syn;
    logic en_sync, vcc_uv_sync, vccp_uv_sync, ov_sync, uv_sync, oc_sync, sw_sync;
    logic clr_all, oc_latched, ov_shut, running, crowbar;

    always_comb begin
        raw_a              = '0;
        raw_a[IDX_EN]      = en_a;
        raw_a[IDX_VCC_UV]  = vcc_uv_a;
        raw_a[IDX_VCCP_UV] = vccp_uv_a;
        raw_a[IDX_OV]      = ov_a;
        raw_a[IDX_UV]      = uv_a;
        raw_a[IDX_OC]      = oc_a;
        raw_a[IDX_SW]      = sw_high_a;
    end

    rfs_sync #(.WIDTH(NUM_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_a(raw_a), .q(syn)
    );

    assign en_sync      = syn[IDX_EN];
    assign vcc_uv_sync  = syn[IDX_VCC_UV];
    assign vccp_uv_sync = syn[IDX_VCCP_UV];
    assign ov_sync      = syn[IDX_OV];
    assign uv_sync      = syn[IDX_UV];
    assign oc_sync      = syn[IDX_OC];
    assign sw_sync      = syn[IDX_SW];

    // Any latched fault and the trip count clear on disable or rail loss.
    assign clr_all = !en_sync || vcc_uv_sync;

    rfs_sticky u_oc_latch (
        .clk(clk), .rst_n(rst_n), .set(oc_sync), .clr(clr_all), .q(oc_latched)
    );

    rfs_ov_counter #(.LIMIT(OV_LIMIT)) u_ov_cnt (
        .clk(clk), .rst_n(rst_n), .clr(clr_all),
        .ov_lvl(ov_sync), .blank(ss_active), .shut(ov_shut)
    );

    assign fault_latched = oc_latched | ov_shut;
    assign running       = en_sync && !vcc_uv_sync && !vccp_uv_sync && !fault_latched;
    assign crowbar       = running && ov_sync && !ss_active;

    assign gate_en       = running;
    assign ss_en         = running;
    assign force_tg_low  = crowbar;
    assign force_bg_high = crowbar || (!running && !vccp_uv_sync && sw_sync);
    assign pgood         = running && !ss_active && !ov_sync && !uv_sync;
    assign ov_thr_sel    = ofs_active;
endmodule

// File: rtl/reg_fault_seq_checker.sv
// Module: property checker for reg_fault_seq, attached by bind.
// Assumes it sees the top ports and the synchronised enable and rail flags.
module reg_fault_seq_checker (
    input logic clk,
    input logic rst_n,
    input logic ss_active,
    input logic gate_en,
    input logic force_tg_low,
    input logic force_bg_high,
    input logic pgood,
    input logic fault_latched,
    input logic en_sync,
    input logic vcc_uv_sync
);
    assert_tg_with_bg_R5: assert property (@(posedge clk) disable iff (!rst_n)
        force_tg_low |-> force_bg_high);
    assert_tg_only_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
        force_tg_low |-> gate_en);
    assert_latched_gates_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched |-> !gate_en);
    assert_no_crowbar_in_ss_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ss_active |-> !force_tg_low);
    assert_pgood_needs_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pgood |-> (gate_en && !ss_active));
    assert_latch_clear_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault_latched) |-> ($past(!en_sync) || $past(vcc_uv_sync)));
endmodule

bind reg_fault_seq reg_fault_seq_checker u_chk (
    .clk(clk), .rst_n(rst_n), .ss_active(ss_active), .gate_en(gate_en),
    .force_tg_low(force_tg_low), .force_bg_high(force_bg_high), .pgood(pgood),
    .fault_latched(fault_latched), .en_sync(en_sync), .vcc_uv_sync(vcc_uv_sync)
);

// File: tb/reg_fault_seq_tb.sv
`timescale 1ns/1ps
module reg_fault_seq_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_a = 0, vcc_uv_a = 0, vccp_uv_a = 0, ov_a = 0, uv_a = 0, oc_a = 0, sw_high_a = 0;
    logic ss_active = 0, ofs_active = 0;
    logic gate_en, ss_en, force_tg_low, force_bg_high, pgood, fault_latched, ov_thr_sel;
    int checks = 0, failures = 0;
    bit done = 0;

    always #2 clk = ~clk;

    reg_fault_seq u_dut (
        .clk(clk), .rst_n(rst_n), .en_a(en_a), .vcc_uv_a(vcc_uv_a), .vccp_uv_a(vccp_uv_a),
        .ov_a(ov_a), .uv_a(uv_a), .oc_a(oc_a), .sw_high_a(sw_high_a),
        .ss_active(ss_active), .ofs_active(ofs_active), .gate_en(gate_en), .ss_en(ss_en),
        .force_tg_low(force_tg_low), .force_bg_high(force_bg_high), .pgood(pgood),
        .fault_latched(fault_latched), .ov_thr_sel(ov_thr_sel)
    );

    // Reference model from the requirements: two-stage delay, counter, latches.
    logic [6:0] m1 = '0, m2 = '0;
    logic m_prev = 0, m_oc = 0, m_shut = 0;
    int   m_cnt = 0;
    always @(posedge clk) begin
        logic clr, rise;
        if (!rst_n) begin
            m1 <= '0; m2 <= '0; m_prev <= 0; m_oc <= 0; m_shut <= 0; m_cnt <= 0;
        end else begin
            m1 <= {sw_high_a, oc_a, uv_a, ov_a, vccp_uv_a, vcc_uv_a, en_a};
            m2 <= m1;
            m_prev <= m2[3];
            clr  = !m2[0] || m2[1];
            rise = m2[3] && !m_prev;
            if (clr) begin m_oc <= 0; m_shut <= 0; m_cnt <= 0; end
            else begin
                if (m2[5]) m_oc <= 1;
                if (rise && !ss_active && !m_shut) begin
                    if (m_cnt == 7) m_shut <= 1; else m_cnt <= m_cnt + 1;
                end
            end
        end
    end

    function automatic logic f_run();
        return m2[0] && !m2[1] && !m2[2] && !(m_oc || m_shut);
    endfunction

    task automatic chk(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic cmp_all();
        logic run;
        run = f_run();
        chk("R10 gate_en", gate_en, run);
        chk("R2 ss_en", ss_en, run);
        chk("R5 force_tg_low", force_tg_low, run && m2[3] && !ss_active);
        chk("R8 force_bg_high", force_bg_high,
            (run && m2[3] && !ss_active) || (!run && !m2[2] && m2[6]));
        chk("R4 pgood", pgood, run && !ss_active && !m2[3] && !m2[4]);
        chk("R6 fault_latched", fault_latched, m_oc || m_shut);
        chk("R9 ov_thr_sel", ov_thr_sel, ofs_active);
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rst_n) cmp_all();
        end
    endtask

    task automatic ov_pulse();
        ov_a = 1; step(4); ov_a = 0; step(4);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        step(3);
        chk("R10 reset gate_en", gate_en, 0);
        chk("R4 reset pgood", pgood, 0);
        chk("R3 reset fault", fault_latched, 0);
        rst_n = 1; en_a = 1; ss_active = 1;
        step(4);
        // R7: trips during soft start neither crowbar nor count.
        for (int i = 0; i < 10; i++) begin
            ov_a = 1; step(3);
            chk("R7 no crowbar in ss", force_tg_low, 0);
            ov_a = 0; step(3);
        end
        ss_active = 0; step(2);
        chk("R7 no latch after ss trips", fault_latched, 0);
        // R6: six pulses, one long level, then the eighth edge latches.
        for (int i = 0; i < 6; i++) ov_pulse();
        ov_a = 1; step(20);
        chk("R5 crowbar bg", force_bg_high, 1);
        chk("R5 pgood low", pgood, 0);
        ov_a = 0; step(4);
        chk("R6 held level counts once", fault_latched, 0);
        chk("R5 released", force_tg_low, 0);
        ov_pulse();
        chk("R6 eighth trip latches", fault_latched, 1);
        chk("R6 gates off", gate_en, 0);
        // R11: enable drop clears; seven further trips stay unlatched.
        en_a = 0; step(4); en_a = 1; step(4);
        chk("R11 cleared", fault_latched, 0);
        for (int i = 0; i < 7; i++) ov_pulse();
        chk("R11 count restarted", fault_latched, 0);
        en_a = 0; step(4); en_a = 1; step(4);
        // R3: overcurrent latches and holds.
        oc_a = 1; step(4); oc_a = 0; step(6);
        chk("R3 oc holds", fault_latched, 1);
        chk("R3 oc gates off", gate_en, 0);
        en_a = 0; step(4); en_a = 1; step(4);
        chk("R3 en clears", fault_latched, 0);
        // R1: undervoltage reaches pgood after exactly two edges.
        @(negedge clk); uv_a = 1;
        @(negedge clk); chk("R1 one edge no change", pgood, 1);
        @(negedge clk); chk("R1 two edges change", pgood, 0);
        uv_a = 0; step(4);
        // R8: switch-node discharge while stopped.
        en_a = 0; sw_high_a = 1; step(4);
        chk("R8 discharge", force_bg_high, 1);
        vccp_uv_a = 1; step(4);
        chk("R8 no discharge without vccp", force_bg_high, 0);
        vccp_uv_a = 0; sw_high_a = 0; en_a = 1; step(4);
        // R2: controller rail loss.
        vcc_uv_a = 1; step(4);
        chk("R2 gates off", gate_en, 0);
        chk("R2 ss off", ss_en, 0);
        vcc_uv_a = 0; step(4);
        // R9: threshold select.
        ofs_active = 1; #1 chk("R9 sel high", ov_thr_sel, 1);
        ofs_active = 0; #1 chk("R9 sel low", ov_thr_sel, 0);
        // Random phase, checked every cycle against the model.
        for (int i = 0; i < 6000; i++) begin
            @(negedge clk);
            cmp_all();
            if ($urandom_range(5) == 0) ov_a = ~ov_a;
            if ($urandom_range(7) == 0) uv_a = ($urandom_range(3) == 0);
            if ($urandom_range(30) == 0) ss_active = ~ss_active;
            if ($urandom_range(20) == 0) ofs_active = ~ofs_active;
            if ($urandom_range(15) == 0) sw_high_a = ~sw_high_a;
            oc_a = ($urandom_range(400) == 0);
            if ($urandom_range(300) == 0) en_a = 0; else if ($urandom_range(6) == 0) en_a = 1;
            if ($urandom_range(500) == 0) vcc_uv_a = 1; else if ($urandom_range(8) == 0) vcc_uv_a = 0;
            if ($urandom_range(500) == 0) vccp_uv_a = 1; else if ($urandom_range(8) == 0) vccp_uv_a = 0;
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule